// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block holds sixteen 32-bit mailbox words for a four-core system, four words per core, and sits on a simple 32-bit register bus. Software raises bits in a mailbox through a write-1-to-set address window. It clears bits or reads the contents through a second window, where writes are write-1-to-clear and reads return the stored word without side effects. Because a mailbox only accumulates bits and never queues, several senders can post separate flag bits into one word. The receiving core clears only the bits it has handled.

For every word the block drives a pending flag that is high while the word holds any set bit. The flags are grouped per core: bits 4c..4c+3 belong to core c. A downstream interrupt router consumes them. Masking and routing are not done here.

Top module: `mbox_bank`

## Requirements
- R1: Mailbox m of core c has index i = 4c+m, and `mbox_pending[i]` is high exactly when word i is nonzero. The flag reflects a write in the cycle after that write's clock edge.
- R2: A write at byte offset 0x80 + 4i (i = 0..15) ORs `bus_wdata` into word i. No other word changes.
- R3: A write at byte offset 0xC0 + 4i clears every bit of word i that is 1 in `bus_wdata`. Bits that are 0 in the data keep their value.
- R4: A read at offset 0xC0 + 4i places word i on `bus_rdata` after the clock edge that samples `bus_rd_en`. Reading does not change any word.
- R5: A read anywhere in the set window 0x80..0xBF returns zero.
- R6: Reset (`rst_n` low) clears all sixteen words, all pending flags and `bus_rdata`.
- R7: Address bits [1:0] are ignored, so any byte offset inside a word selects that word.
- R8: Writes below offset 0x80 change nothing, and reads there return zero.
- R9: While `bus_rd_en` is low, `bus_rdata` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| mbox_pending | output | 16 | Nonzero flag per word, bit 4c+m for core c, mailbox m |

## Verification
The hardest case to reach is a word whose bits were posted by several separate set writes and then retired in pieces. There, a wrong merge or a mask applied the wrong way round would leave the pending flag on the wrong side of zero. The stimulus sweeps every word with two overlapping set patterns, then with a partial clear mask, then with a full clear. It compares the full 16-bit pending vector against an arithmetic model after every single write. This exposes a drop of a pending flag on the wrong step, or one word's access leaking into a neighbour.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NWORDS   = 16,
    parameter int SET_BASE = 128,
    parameter int IDX_W    = $clog2(NWORDS)
) (
    input  logic [AW-1:0]    addr,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] idx
);
    localparam int SPAN     = NWORDS * 4;
    localparam int CLR_BASE = SET_BASE + SPAN;
    localparam int LIMIT    = CLR_BASE + SPAN;

    always_comb begin
        int a;
        a    = int'(addr);
        kind = ACC_NONE;
        idx  = '0;
        if (a >= SET_BASE && a < CLR_BASE) begin
            kind = ACC_SET;
            idx  = IDX_W'((a - SET_BASE) >> 2);
        end else if (a >= CLR_BASE && a < LIMIT) begin
            kind = ACC_CLR;
            idx  = IDX_W'((a - CLR_BASE) >> 2);
        end
    end
endmodule

// File: rtl/mbox_word.sv
module mbox_word #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] value,
    output logic          pending
);
    typedef struct packed {
        logic [DW-1:0] word;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en)
            st_d.word = st_q.word | mask;
        else if (clr_en)
            st_d.word = st_q.word & ~mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value   = st_q.word;
    assign pending = |st_q.word;

    AST_SET_MERGES: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> value == ($past(value) | $past(mask))); // R2
    AST_CLR_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> value == ($past(value) & ~$past(mask))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(value)); // R4
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int NCORES   = 4,
    parameter int PER_CORE = 4,
    parameter int DW       = 32,
    parameter int AW       = 8,
    parameter int SET_BASE = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr_en,
    input  logic                        bus_rd_en,
    input  logic [AW-1:0]               bus_addr,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    output logic [NCORES*PER_CORE-1:0]  mbox_pending
);
    localparam int NWORDS = NCORES * PER_CORE;
    localparam int IDX_W  = $clog2(NWORDS);

    acc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [NWORDS-1:0]  set_en, clr_en;
    logic [DW-1:0]      words [NWORDS];

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    mbox_decode #(
        .AW(AW), .NWORDS(NWORDS), .SET_BASE(SET_BASE), .IDX_W(IDX_W)
    ) u_decode (
        .addr(bus_addr),
        .kind(kind),
        .idx (idx)
    );

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        assign set_en[i] = bus_wr_en && (kind == ACC_SET) && (idx == IDX_W'(i));
        assign clr_en[i] = bus_wr_en && (kind == ACC_CLR) && (idx == IDX_W'(i));

        mbox_word #(.DW(DW)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (set_en[i]),
            .clr_en (clr_en[i]),
            .mask   (bus_wdata),
            .value  (words[i]),
            .pending(mbox_pending[i])
        );
    end

    always_comb begin
        rd_d = rd_q;
        if (bus_rd_en) begin
            if (kind == ACC_CLR) rd_d.rdata = words[idx];
            else                 rd_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_en | clr_en)); // R2
    AST_SET_WINDOW_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && kind == ACC_SET) |=> bus_rdata == '0); // R5
    AST_LOW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && kind == ACC_NONE) |=> $stable(mbox_pending)); // R8
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/mbox_bank_test.sv
module mbox_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] mbox_pending;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [31:0] model [16];

    always #2.5 clk = ~clk;

    mbox_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mbox_pending(mbox_pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pend_model();
        logic [15:0] p;
        for (int i = 0; i < 16; i++) p[i] = (model[i] != 0);
        return p;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 pending after reset", {16'h0, mbox_pending}, 32'h0);
        chk("R6 rdata after reset", bus_rdata, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd(8'(8'hC0 + 4 * i));
            chk("R6 word zero after reset", bus_rdata, 32'h0);
        end

        // R2 / R1: two overlapping set patterns per word
        for (int i = 0; i < 16; i++) begin
            logic [31:0] p1, p2;
            p1 = (32'h1 << i) ^ (32'(i) * 32'h0011_0101);
            p2 = 32'h8000_0000 >> i;
            wr(8'(8'h80 + 4 * i), p1);
            model[i] |= p1;
            chk("R1 pending after first set", {16'h0, mbox_pending}, {16'h0, pend_model()});
            wr(8'(8'h80 + 4 * i), p2);
            model[i] |= p2;
            chk("R1 pending after second set", {16'h0, mbox_pending}, {16'h0, pend_model()});
        end
        for (int i = 0; i < 16; i++) begin
            rd(8'(8'hC0 + 4 * i));
            chk("R2 merged word", bus_rdata, model[i]);
            rd(8'(8'hC0 + 4 * i));
            chk("R4 second read unchanged", bus_rdata, model[i]);
        end

        // R5: set window reads zero, no effect on state
        for (int i = 0; i < 16; i++) begin
            rd(8'(8'hC0 + 4 * i));
            rd(8'(8'h80 + 4 * i));
            chk("R5 set window read", bus_rdata, 32'h0);
        end
        chk("R4 pending unchanged by reads", {16'h0, mbox_pending}, {16'h0, pend_model()});

        // R9: rdata holds while read strobe low
        rd(8'hC0 + 8'd12);
        @(negedge clk); bus_addr = 8'hC4;
        repeat (3) @(negedge clk);
        chk("R9 rdata holds", bus_rdata, model[3]);

        // R3: partial clear then full clear
        for (int i = 0; i < 16; i++) begin
            wr(8'(8'hC0 + 4 * i), 32'h5555_5555);
            model[i] &= ~32'h5555_5555;
            rd(8'(8'hC0 + 4 * i));
            chk("R3 partial clear", bus_rdata, model[i]);
            chk("R1 pending after partial clear", {16'h0, mbox_pending}, {16'h0, pend_model()});
        end
        for (int i = 0; i < 16; i++) begin
            wr(8'(8'hC0 + 4 * i), 32'hFFFF_FFFF);
            model[i] = '0;
            chk("R1 pending drops on full clear", {16'h0, mbox_pending}, {16'h0, pend_model()});
        end

        // R7: low address bits ignored
        wr(8'h80 + 8'd22, 32'h0000_00F0);
        model[5] |= 32'h0000_00F0;
        wr(8'h80 + 8'd21, 32'h0000_0F00);
        model[5] |= 32'h0000_0F00;
        rd(8'hC0 + 8'd23);
        chk("R7 sub-word offset", bus_rdata, model[5]);
        wr(8'hC0 + 8'd21, 32'h0000_0030);
        model[5] &= ~32'h0000_0030;
        rd(8'hC0 + 8'd20);
        chk("R7 clear sub-word offset", bus_rdata, model[5]);
        chk("R7 pending", {16'h0, mbox_pending}, {16'h0, pend_model()});

        // R8: below the windows
        for (int a = 0; a < 128; a += 4) begin
            wr(8'(a), 32'hFFFF_FFFF);
        end
        chk("R8 low writes ignored", {16'h0, mbox_pending}, {16'h0, pend_model()});
        rd(8'hC0 + 8'd20);
        chk("R8 word 5 untouched", bus_rdata, model[5]);
        rd(8'h14);
        chk("R8 low read zero", bus_rdata, 32'h0);

        // R6: reset mid-run
        wr(8'h80, 32'h1); wr(8'hBC, 32'h2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
        chk("R6 pending after mid reset", {16'h0, mbox_pending}, 32'h0);
        rd(8'hFC);
        chk("R6 word 15 cleared", bus_rdata, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule